// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block runs the address and data cycles of an enhanced parallel port. It sits beside the basic port registers. The host sends one access at a time over a valid/ready request channel. Offset 3 starts an address cycle, offset 4 starts a data cycle, and offset 1 reads or writes the status view. Any other offset is accepted and completed without touching the peripheral. The live control register byte of the basic port is an input. The block compares it with one fixed pattern for writes and another for reads. When the pattern does not match, the cycle is skipped.

A permitted cycle becomes one or more byte handshakes. For each byte the block raises the address strobe or the data strobe and holds it until the peripheral acknowledges. The wait is bounded. Data accesses at offset 4 may be 1, 2 or 4 bytes wide and move least-significant byte first. When a byte is not acknowledged in time, the remaining bytes are dropped and a sticky timeout flag is set. That flag appears as bit 0 of every status read until the host writes a 1 to that bit.

Back-pressure: `req_ready` is high only while the block is idle, and a request moves when `req_valid` and `req_ready` are both high at a clock edge. Every accepted request produces exactly one single-cycle `rsp_valid` pulse, and `req_ready` stays low until that pulse has passed. The response channel has no ready signal: the host must take `rsp_rdata` in the pulse cycle.

Top module: `epp_gate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, both strobes are 0 and `timeout_flag` is 0.
- R2: A write at offset 3 or 4 runs only when `ctrl_reg & 8'h2F == 8'h04`. Those bits are bit 5 direction, bit 3 select, bit 2 init, bit 1 auto-linefeed and bit 0 strobe. Otherwise no strobe is raised. Every write response carries data 0.
- R3: A read at offset 3 or 4 runs only when `ctrl_reg & 8'h2F == 8'h24`. Otherwise no strobe is raised and the response is all ones at the access width, with zeros above it.
- R4: Offset 3 raises only `pp_addr_stb` and offset 4 raises only `pp_data_stb`. `pp_write` is 1 for writes. `pp_dir` equals `ctrl_reg` bit 5.
- R5: At offset 4, `req_size` 0, 1 and 2 move 1, 2 and 4 bytes. Byte i of the transfer is `req_wdata[8i+7:8i]` for writes and lands in `rsp_rdata[8i+7:8i]` for reads. Other offsets always move one byte.
- R6: Each byte keeps its strobe high until `pp_ack` is sampled high. The strobe then drops for at least one cycle before the next byte.
- R7: A strobe held for `TIMEOUT_CYC` cycles (default 64) without `pp_ack` ends the access. The remaining bytes are skipped and `timeout_flag` becomes 1. An ack arriving in the last allowed cycle still succeeds. Bytes of an aborted read that were never received read as ones.
- R8: A read at offset 1 returns `periph_status` with bit 0 replaced by `timeout_flag`.
- R9: A write at offset 1 with data bit 0 = 1 clears `timeout_flag`. A write there with bit 0 = 0 leaves the flag unchanged.
- R10: `req_ready` is 0 from acceptance until the response pulse has passed. `rsp_valid` is never high in two consecutive cycles.
- R11: Offsets other than 1, 3 and 4 raise no strobe. A read at those offsets returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_size | input | 2 | Data width at offset 4: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Response data, valid with rsp_valid |
| ctrl_reg | input | 8 | Current basic-port control byte |
| periph_status | input | 8 | Status lines from the peripheral |
| timeout_flag | output | 1 | Sticky timeout flag |
| pp_addr_stb | output | 1 | Address-cycle strobe |
| pp_data_stb | output | 1 | Data-cycle strobe |
| pp_write | output | 1 | Current cycle is a write |
| pp_dir | output | 1 | Peripheral data bus direction, 1 = input |
| pp_dout | output | 8 | Byte driven to the peripheral |
| pp_din | input | 8 | Byte from the peripheral |
| pp_ack | input | 1 | Peripheral acknowledge for the current byte |

## Verification
If the gate decode is wrong, a strobe appears for a dropped access, or a permitted one completes with no strobe at all. Both show within two cycles of acceptance. A wrong byte index or lane capture shows as a misordered `pp_dout` byte or a swapped `rsp_rdata` lane in the same access. A fault in the wait counter or in the flag logic shows at the boundary where the ack comes one cycle too late. There the strobe count, the response timing and the very next status read all disagree with the expected outcome.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_GAP,
    ST_DONE
  } epp_state_t;

  localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTL_WR_OK     = 8'h04;
  localparam logic [7:0] CTL_RD_OK     = 8'h24;
  localparam logic [7:0] STAT_KEEP     = 8'hFE;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;
endpackage

// File: rtl/epp_gate_permit.sv
module epp_gate_permit
  import epp_gate_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int IDX_W = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic [7:0]    ctrl,
  input  logic [2:0]    addr,
  input  logic          write,
  input  logic [1:0]    size,
  output logic          run,
  output logic          is_addr,
  output logic [IDX_W-1:0] last_idx,
  output logic [DW-1:0] width_mask
);
  logic cycle_ofs;
  logic gate_ok;

  assign cycle_ofs = (addr == OFS_ADDR) || (addr == OFS_DATA);
  assign is_addr   = (addr == OFS_ADDR);
  assign gate_ok   = write ? ((ctrl & CTL_GATE_MASK) == CTL_WR_OK)
                           : ((ctrl & CTL_GATE_MASK) == CTL_RD_OK);
  assign run       = cycle_ofs && gate_ok;

  always_comb begin
    last_idx = '0;
    if (addr == OFS_DATA) begin
      case (size)
        2'd0:    last_idx = '0;
        2'd1:    last_idx = IDX_W'(1);
        default: last_idx = IDX_W'(BYTES - 1);
      endcase
    end
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_mask
    assign width_mask[8*i +: 8] = (IDX_W'(i) <= last_idx) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/epp_gate_timer.sv
module epp_gate_timer #(
  parameter int TIMEOUT_CYC = 64,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic acked,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = active && !acked && (cnt == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || acked) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/epp_gate_lanes.sv
module epp_gate_lanes #(
  parameter int BYTES = 4,
  localparam int IDX_W = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             capture,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [DW-1:0]    word
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[8*i +: 8] <= 8'hFF;
      end else if (preset) begin
        word[8*i +: 8] <= 8'hFF;
      end else if (capture && (idx == IDX_W'(i))) begin
        word[8*i +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/epp_gate.sv
module epp_gate
  import epp_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int BYTES = 4,
  localparam int IDX_W = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [2:0]    req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic [7:0]    ctrl_reg,
  input  logic [7:0]    periph_status,
  output logic          timeout_flag,
  output logic          pp_addr_stb,
  output logic          pp_data_stb,
  output logic          pp_write,
  output logic          pp_dir,
  output logic [7:0]    pp_dout,
  input  logic [7:0]    pp_din,
  input  logic          pp_ack
);
  epp_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lat_last;
  logic             lat_write;
  logic             lat_addr_cyc;
  logic [DW-1:0]    lat_wdata;
  logic [DW-1:0]    lat_mask;
  logic [DW-1:0]    resp_word;
  logic             resp_lanes;
  logic             flag;

  logic             dec_run;
  logic             dec_is_addr;
  logic [IDX_W-1:0] dec_last;
  logic [DW-1:0]    dec_mask;
  logic             accept;
  logic             in_strobe;
  logic             expired;
  logic [DW-1:0]    lane_word;

  epp_gate_permit #(.BYTES(BYTES)) u_permit (
    .ctrl       (ctrl_reg),
    .addr       (req_addr),
    .write      (req_write),
    .size       (req_size),
    .run        (dec_run),
    .is_addr    (dec_is_addr),
    .last_idx   (dec_last),
    .width_mask (dec_mask)
  );

  epp_gate_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (in_strobe),
    .acked   (pp_ack),
    .expired (expired)
  );

  epp_gate_lanes #(.BYTES(BYTES)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .preset  (accept),
    .capture (in_strobe && pp_ack && !lat_write),
    .idx     (idx),
    .din     (pp_din),
    .word    (lane_word)
  );

  assign req_ready    = (state == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign in_strobe    = (state == ST_STROBE);
  assign pp_addr_stb  = in_strobe && lat_addr_cyc;
  assign pp_data_stb  = in_strobe && !lat_addr_cyc;
  assign pp_write     = lat_write;
  assign pp_dir       = ctrl_reg[5];
  assign pp_dout      = lat_wdata[8*idx +: 8];
  assign rsp_valid    = (state == ST_DONE);
  assign rsp_rdata    = resp_lanes ? (lane_word & lat_mask) : resp_word;
  assign timeout_flag = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      idx          <= '0;
      lat_last     <= '0;
      lat_write    <= 1'b0;
      lat_addr_cyc <= 1'b0;
      lat_wdata    <= '0;
      lat_mask     <= '0;
      resp_word    <= '0;
      resp_lanes   <= 1'b0;
      flag         <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            idx          <= '0;
            lat_last     <= dec_last;
            lat_write    <= req_write;
            lat_addr_cyc <= dec_is_addr;
            lat_wdata    <= req_wdata;
            lat_mask     <= dec_mask;
            resp_lanes   <= dec_run && !req_write;
            if (req_write) begin
              resp_word <= '0;
            end else if (req_addr == OFS_STATUS) begin
              resp_word <= DW'((periph_status & STAT_KEEP) | {7'd0, flag});
            end else begin
              resp_word <= dec_mask;
            end
            if (req_write && (req_addr == OFS_STATUS) && req_wdata[0]) begin
              flag <= 1'b0;
            end
            state <= dec_run ? ST_STROBE : ST_DONE;
          end
        end
        ST_STROBE: begin
          if (pp_ack) begin
            state <= (idx == lat_last) ? ST_DONE : ST_GAP;
          end else if (expired) begin
            flag  <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_GAP: begin
          idx   <= idx + IDX_W'(1);
          state <= ST_STROBE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk #(
  parameter int TIMEOUT_CYC = 64,
  localparam int HW = $clog2(TIMEOUT_CYC + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [2:0] req_addr,
  input logic       wdata_b0,
  input logic       rsp_valid,
  input logic       pp_addr_stb,
  input logic       pp_data_stb,
  input logic       pp_ack,
  input logic       timeout_flag
);
  logic          stb;
  logic [HW-1:0] hi_cnt;

  assign stb = pp_addr_stb || pp_data_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!stb) begin
      hi_cnt <= '0;
    end else if (hi_cnt <= HW'(TIMEOUT_CYC)) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pp_addr_stb, pp_data_stb}));

  // R10
  busy_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> !req_ready);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && pp_ack) |=> !stb);

  // R7
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= HW'(TIMEOUT_CYC));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(stb));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_flag) |-> $past(req_valid && req_ready && req_write &&
                                  (req_addr == 3'd1) && wdata_b0));
endmodule

bind epp_gate epp_gate_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .wdata_b0     (req_wdata[0]),
  .rsp_valid    (rsp_valid),
  .pp_addr_stb  (pp_addr_stb),
  .pp_data_stb  (pp_data_stb),
  .pp_ack       (pp_ack),
  .timeout_flag (timeout_flag)
);

// File: tb/tb_epp_gate.sv
`timescale 1ns/1ps
module tb_epp_gate;
  localparam int T = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  ctrl_reg = 8'h0C;
  logic [7:0]  periph_status = 8'h5F;
  logic        timeout_flag;
  logic        pp_addr_stb, pp_data_stb, pp_write, pp_dir;
  logic [7:0]  pp_dout;
  logic [7:0]  pp_din = 8'h00;
  logic        pp_ack = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  epp_gate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctrl_reg(ctrl_reg), .periph_status(periph_status),
    .timeout_flag(timeout_flag), .pp_addr_stb(pp_addr_stb),
    .pp_data_stb(pp_data_stb), .pp_write(pp_write), .pp_dir(pp_dir),
    .pp_dout(pp_dout), .pp_din(pp_din), .pp_ack(pp_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboards
  logic [31:0] exp_rsp[$];
  string       exp_rsp_tag[$];
  logic [9:0]  exp_stb[$];   // {is_addr, is_write, byte}
  string       exp_stb_tag[$];

  // peripheral model
  int         pdelay = 2;
  int         budget = -1;
  int         scnt = 0;
  logic [7:0] rd_ctr = 8'h30;

  always @(negedge clk) begin
    if (pp_addr_stb || pp_data_stb) begin
      if (scnt == 0) begin
        if (exp_stb.size() == 0) begin
          check("R2 unexpected strobe", 32'd1, 32'd0);
        end else begin
          logic [9:0] e;
          string tg;
          e  = exp_stb.pop_front();
          tg = exp_stb_tag.pop_front();
          check({tg, " addr strobe"}, {31'd0, pp_addr_stb}, {31'd0, e[9]});
          check({tg, " R4 write"}, {31'd0, pp_write}, {31'd0, e[8]});
          check({tg, " R4 dir"}, {31'd0, pp_dir}, {31'd0, !e[8]});
          if (e[8]) check({tg, " R5 byte"}, {24'd0, pp_dout}, {24'd0, e[7:0]});
        end
      end
      if (!pp_ack && scnt == pdelay && budget != 0) begin
        pp_ack = 1'b1;
        pp_din = rd_ctr;
        if (!pp_write) rd_ctr = rd_ctr + 8'd1;
        if (budget > 0) budget--;
      end
      scnt++;
    end else begin
      pp_ack = 1'b0;
      scnt = 0;
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_rsp.size() == 0) begin
        check("R10 unexpected response", 32'd1, 32'd0);
      end else begin
        string tg;
        tg = exp_rsp_tag.pop_front();
        check(tg, rsp_rdata, exp_rsp.pop_front());
      end
    end
  end

  // driver with independent model
  logic       mflag = 1'b0;
  logic [7:0] pred_ctr = 8'h30;

  task automatic access(input string tag, input logic w, input logic [2:0] a,
                        input logic [1:0] sz, input logic [31:0] wd);
    int nb, acks, nstb;
    logic run;
    logic [31:0] exp, mask;
    nb   = (a == 3'd4) ? ((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4) : 1;
    mask = (nb == 4) ? 32'hFFFF_FFFF : (32'h1 << (8 * nb)) - 32'h1;
    run  = ((a == 3'd3) || (a == 3'd4)) &&
           (w ? ((ctrl_reg & 8'h2F) == 8'h04) : ((ctrl_reg & 8'h2F) == 8'h24));
    exp  = w ? 32'h0 : mask;
    if (a == 3'd1 && !w) exp = {24'd0, periph_status[7:1], mflag};
    if (run) begin
      acks = (pdelay >= T) ? 0 : ((budget < 0 || budget >= nb) ? nb : budget);
      nstb = (acks < nb) ? acks + 1 : nb;
      for (int i = 0; i < nstb; i++) begin
        exp_stb.push_back({a == 3'd3, w, wd[8*i +: 8]});
        exp_stb_tag.push_back(tag);
      end
      if (!w) begin
        for (int i = 0; i < acks; i++) begin
          exp[8*i +: 8] = pred_ctr;
          pred_ctr = pred_ctr + 8'd1;
        end
      end
      if (acks < nb) mflag = 1'b1;
    end
    if (w && a == 3'd1 && wd[0]) mflag = 1'b0;
    exp_rsp.push_back(exp);
    exp_rsp_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    check({tag, " R7 flag"}, {31'd0, timeout_flag}, {31'd0, mflag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 strobes", {30'd0, pp_addr_stb, pp_data_stb}, 32'd0);
    check("R1 flag", {31'd0, timeout_flag}, 32'd0);
    check("R1 rsp", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    access("R8 status clean", 1'b0, 3'd1, 2'd0, 0);
    ctrl_reg = 8'h04;
    access("R4 addr write", 1'b1, 3'd3, 2'd0, 32'h0000_003C);
    access("R5 word write", 1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF);
    ctrl_reg = 8'hD4;
    access("R2 upper bits ignored", 1'b1, 3'd4, 2'd1, 32'h0000_1234);
    ctrl_reg = 8'h0C;
    access("R2 select set drop", 1'b1, 3'd4, 2'd0, 32'h55);
    ctrl_reg = 8'h24;
    access("R2 dir set drop", 1'b1, 3'd3, 2'd0, 32'h66);
    ctrl_reg = 8'h05;
    access("R2 strobe set drop", 1'b1, 3'd4, 2'd2, 32'h1122_3344);
    ctrl_reg = 8'h24;
    access("R3 addr read", 1'b0, 3'd3, 2'd0, 0);
    pdelay = 0;
    access("R5 byte read", 1'b0, 3'd4, 2'd0, 0);
    pdelay = 3;
    access("R5 half read", 1'b0, 3'd4, 2'd1, 0);
    access("R5 word read", 1'b0, 3'd4, 2'd2, 0);
    ctrl_reg = 8'h04;
    access("R3 skip half", 1'b0, 3'd4, 2'd1, 0);
    ctrl_reg = 8'h2C;
    access("R3 skip word", 1'b0, 3'd4, 2'd2, 0);
    access("R3 skip addr", 1'b0, 3'd3, 2'd0, 0);

    ctrl_reg = 8'h04;
    pdelay = T - 1;
    access("R7 last cycle ack", 1'b1, 3'd4, 2'd0, 32'hA5);
    pdelay = T;
    access("R7 timeout write", 1'b1, 3'd4, 2'd2, 32'h0102_0304);
    periph_status = 8'hA6;
    access("R8 status timeout", 1'b0, 3'd1, 2'd0, 0);
    access("R9 write zero keeps", 1'b1, 3'd1, 2'd0, 32'hFE);
    access("R8 status kept", 1'b0, 3'd1, 2'd0, 0);
    access("R9 clear", 1'b1, 3'd1, 2'd0, 32'h01);
    periph_status = 8'h5F;
    access("R8 status cleared", 1'b0, 3'd1, 2'd0, 0);

    ctrl_reg = 8'h24;
    pdelay = 1;
    budget = 2;
    access("R7 partial read", 1'b0, 3'd4, 2'd2, 0);
    budget = -1;
    access("R9 clear again", 1'b1, 3'd1, 2'd0, 32'h01);
    access("R11 offset0 read", 1'b0, 3'd0, 2'd0, 0);
    access("R11 offset5 read", 1'b0, 3'd5, 2'd2, 0);
    ctrl_reg = 8'h04;
    access("R11 offset7 write", 1'b1, 3'd7, 2'd0, 32'h77);
    access("R11 offset2 write", 1'b1, 3'd2, 2'd0, 32'h04);

    repeat (4) @(negedge clk);
    check("R10 responses drained", exp_rsp.size(), 0);
    check("R6 strobes drained", exp_stb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule